// File: doc/BRIEF.md
# Big-Integer Dword Reorder Engine

This block takes a big integer delivered as a byte string, most significant byte first and left-aligned. It turns that string into the sequence of 64-bit words that a little-endian wide-word arithmetic unit consumes. Bytes enter one per handshake on a valid/ready stream. The block holds the whole operand in an internal buffer before it emits anything. It then releases 64-bit words on a second valid/ready stream, starting with the eight-byte group at the end of the string and working back toward the start. A last flag marks the final word.

A transfer starts with a one-cycle start strobe that carries the operand length in bytes. The block holds at most one operand at a time. Because the complete operand is captured before the first word leaves, a caller may convert an operand in place: it can read the source from the same storage it later writes the result to. Lengths the block cannot handle are refused with a one-cycle error pulse, and no transfer takes place.

Top module: `bigint_word_reorder`

## Requirements
- R1: While reset is asserted, and until the first start after reset, in_ready_o, out_valid_o and err_o are all low.
- R2: A start_i pulse in idle with a legal length (non-zero, at most 256, a multiple of 8) raises in_ready_o in the next cycle. Exactly that many bytes are then accepted, and in_ready_o is low in the cycle after the final byte is taken.
- R3: A start_i pulse in idle with an illegal length drives err_o high for exactly the following cycle. In_ready_o and out_valid_o stay low, and the block remains idle.
- R4: While out_valid_o is high and out_ready_i is low, out_data_o and out_last_o hold their values into the next cycle.
- R5: For an operand of L bytes b[0..L-1], output word k (k counted from 0 in emission order) has b[L-8-8k+j] in bits [8j+7:8j], for j = 0..7.
- R6: Exactly L/8 words are emitted, and out_last_o is high only on word L/8-1.
- R7: A start_i pulse while bytes are being loaded or words are being emitted has no effect. The length, the data and the word count of the operand in progress are unchanged, and err_o stays low.
- R8: After the last word is taken, out_valid_o and in_ready_o are both low. Bytes offered before the next start are not accepted.
- R9: Gaps in in_valid_i and stalls on out_ready_i do not change the emitted words.
- R10: out_valid_o stays low while the operand is loading, and in_ready_o and out_valid_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request, sampled in idle |
| len_i | input | 10 | Operand length in bytes, sampled with start_i |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte, most significant byte of the string first |
| in_ready_o | output | 1 | Block accepts an input byte |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 64 | Output word |
| out_last_o | output | 1 | Marks the final word of the operand |
| out_ready_i | input | 1 | Consumer accepts the output word |
| err_o | output | 1 | One-cycle pulse for a refused length |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of an operand. It is only observable as an absence of effect, and only if the pulse lands while loading or emitting rather than in idle. Directed operands therefore pulse start_i with a different legal length at the second input byte and again on the first output word, and every emitted word and the last flag are then checked against the original length. Random operands combine lengths from 8 to 256 bytes with random input gaps and output stalls, so the hold-under-stall and group-reversal paths are exercised across every word position.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2
  } bwr_state_e;
endpackage

// File: rtl/bwr_rst_sync.sv
module bwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bwr_store.sv
module bwr_store #(
  parameter int MAX_BYTES  = 256,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          wr_en_i,
  input  logic [$clog2(MAX_BYTES)-1:0]  wr_idx_i,
  input  logic [7:0]                    wr_byte_i,
  input  logic [$clog2(MAX_BYTES/WORD_BYTES)-1:0] rd_word_i,
  output logic [8*WORD_BYTES-1:0]       rd_data_o
);
  localparam int NWORDS = MAX_BYTES / WORD_BYTES;
  localparam int CNT_W  = $clog2(MAX_BYTES);
  localparam int OFF_W  = $clog2(WORD_BYTES);

  // Byte b of a group lands in lane b, so the first string byte of a group
  // ends up in the least significant lane of the emitted word.
  logic [7:0] byte_q [NWORDS][WORD_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en_i) byte_q[wr_idx_i[CNT_W-1:OFF_W]][wr_idx_i[OFF_W-1:0]] <= wr_byte_i;
  end

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign rd_data_o[8*b +: 8] = byte_q[rd_word_i][b];
  end
endmodule

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
  import bwr_pkg::*;
#(
  parameter int MAX_BYTES  = 256,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [$clog2(MAX_BYTES)+1:0]  len_i,
  input  logic                          in_valid_i,
  input  logic                          out_ready_i,
  output logic                          in_ready_o,
  output logic                          wr_en_o,
  output logic [$clog2(MAX_BYTES)-1:0]  wr_idx_o,
  output logic                          out_valid_o,
  output logic [$clog2(MAX_BYTES/WORD_BYTES)-1:0] rd_word_o,
  output logic                          out_last_o,
  output logic                          err_o
);
  localparam int LEN_W  = $clog2(MAX_BYTES) + 2;
  localparam int CNT_W  = $clog2(MAX_BYTES);
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int WIDX_W = $clog2(MAX_BYTES / WORD_BYTES);

  bwr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  top_q, top_d;
  logic [WIDX_W-1:0] grp_q, grp_d;
  logic              err_q, err_d;
  logic              cnt_en, top_en, grp_en;
  logic              len_legal;
  logic [LEN_W-1:0]  len_m1;

  assign len_m1    = len_i - LEN_W'(1);
  assign len_legal = (len_i != '0) && (len_i <= LEN_W'(MAX_BYTES)) &&
                     (len_i[OFF_W-1:0] == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    top_d   = top_q;
    grp_d   = grp_q;
    err_d   = 1'b0;
    cnt_en  = 1'b0;
    top_en  = 1'b0;
    grp_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (len_legal) begin
            state_d = ST_LOAD;
            cnt_d   = '0;
            top_d   = len_m1[CNT_W-1:0];
            cnt_en  = 1'b1;
            top_en  = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (in_valid_i) begin
          cnt_d  = cnt_q + CNT_W'(1);
          cnt_en = 1'b1;
          if (cnt_q == top_q) begin
            state_d = ST_EMIT;
            grp_d   = top_q[CNT_W-1:OFF_W];
            grp_en  = 1'b1;
          end
        end
      end
      ST_EMIT: begin
        if (out_ready_i) begin
          if (grp_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            grp_d  = grp_q - WIDX_W'(1);
            grp_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      top_q   <= '0;
      grp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (top_en) top_q <= top_d;
      if (grp_en) grp_q <= grp_d;
    end
  end

  assign in_ready_o  = (state_q == ST_LOAD);
  assign wr_en_o     = in_ready_o && in_valid_i;
  assign wr_idx_o    = cnt_q;
  assign out_valid_o = (state_q == ST_EMIT);
  assign rd_word_o   = grp_q;
  assign out_last_o  = out_valid_o && (grp_q == '0);
  assign err_o       = err_q;
endmodule

// File: rtl/bigint_word_reorder.sv
module bigint_word_reorder #(
  parameter int MAX_BYTES  = 256,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [$clog2(MAX_BYTES)+1:0]  len_i,
  input  logic                          in_valid_i,
  input  logic [7:0]                    in_data_i,
  output logic                          in_ready_o,
  output logic                          out_valid_o,
  output logic [8*WORD_BYTES-1:0]       out_data_o,
  output logic                          out_last_o,
  input  logic                          out_ready_i,
  output logic                          err_o
);
  localparam int CNT_W  = $clog2(MAX_BYTES);
  localparam int WIDX_W = $clog2(MAX_BYTES / WORD_BYTES);
  localparam int DATA_W = 8 * WORD_BYTES;

  logic              rst_sync_n;
  logic              wr_en;
  logic [CNT_W-1:0]  wr_idx;
  logic [WIDX_W-1:0] rd_word;

  bwr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bwr_ctrl #(.MAX_BYTES(MAX_BYTES), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .out_valid_o (out_valid_o),
    .rd_word_o   (rd_word),
    .out_last_o  (out_last_o),
    .err_o       (err_o)
  );

  bwr_store #(.MAX_BYTES(MAX_BYTES), .WORD_BYTES(WORD_BYTES)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_byte_i (in_data_i),
    .rd_word_i (rd_word),
    .rd_data_o (out_data_o)
  );
endmodule

// File: rtl/bwr_chk.sv
module bwr_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              err
);
  // R4: a stalled word and its last flag hold steady
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R3: the refusal pulse comes only while idle
  p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready && !out_valid);

  // R7: no refusal can follow a busy cycle
  p_busy_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready || out_valid |=> !err);

  // R10: loading and emitting never overlap
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R6: the last flag is only seen on a valid word
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8: after the final word is taken the block goes quiet
  p_last_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && !in_ready);
endmodule

bind bigint_word_reorder bwr_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_ready  (in_ready_o),
  .out_valid (out_valid_o),
  .out_ready (out_ready_i),
  .out_data  (out_data_o),
  .out_last  (out_last_o),
  .err       (err_o)
);

// File: tb/test_bigint_word_reorder.sv
module test_bigint_word_reorder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [9:0]  len_i;
  logic        in_valid_i;
  logic [7:0]  in_data_i;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [63:0] out_data_o;
  logic        out_last_o;
  logic        out_ready_i;
  logic        err_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] buf_q [256];

  always #2 clk = ~clk;

  bigint_word_reorder i_bigint_word_reorder (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .out_ready_i (out_ready_i),
    .err_o       (err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(input int len, input int k);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = buf_q[len - 8 - 8*k + j];
    return w;
  endfunction

  task automatic run_op(input int len, input int in_pct, input int out_pct,
                        input bit poke);
    bit legal;
    int idx;
    int k;
    bit fire;
    bit hold;
    logic [63:0] prev;
    logic        prev_last;
    legal = (len > 0) && (len <= 256) && (len % 8 == 0);
    @(negedge clk);
    start_i = 1'b1;
    len_i   = len[9:0];
    @(negedge clk);
    start_i = 1'b0;
    if (!legal) begin
      check(err_o && !in_ready_o && !out_valid_o, "R3", "refusal pulse",
            {61'd0, err_o, in_ready_o, out_valid_o}, 64'd4);
      @(negedge clk);
      check(!err_o && !in_ready_o && !out_valid_o, "R3", "pulse ends, stays idle",
            {61'd0, err_o, in_ready_o, out_valid_o}, 64'd0);
      return;
    end
    check(in_ready_o && !err_o, "R2", "ready after start",
          {62'd0, in_ready_o, err_o}, 64'd2);
    idx = 0;
    while (idx < len) begin
      in_valid_i = ($urandom_range(99) < in_pct);
      in_data_i  = buf_q[idx];
      if (poke && idx == 1) begin
        start_i = 1'b1;
        len_i   = 10'd8;
      end
      check(!out_valid_o, "R10", "no output while loading",
            {63'd0, out_valid_o}, 64'd0);
      fire = in_valid_i && in_ready_o;
      @(negedge clk);
      start_i = 1'b0;
      if (fire) idx++;
    end
    in_valid_i = 1'b0;
    check(!in_ready_o && out_valid_o, "R2", "load closes after last byte",
          {62'd0, in_ready_o, out_valid_o}, 64'd1);
    k = 0;
    hold = 1'b0;
    prev = '0;
    prev_last = 1'b0;
    while (k < len / 8) begin
      out_ready_i = ($urandom_range(99) < out_pct);
      if (poke && k == 0) begin
        start_i = 1'b1;
        len_i   = 10'd8;
      end
      if (hold) check(out_data_o == prev && out_last_o == prev_last, "R4",
                      "stalled word held", out_data_o, prev);
      check(out_valid_o && !in_ready_o && !err_o, "R8", "emit state, no input",
            {61'd0, out_valid_o, in_ready_o, err_o}, 64'd4);
      fire = out_valid_o && out_ready_i;
      if (fire) begin
        check(out_data_o == exp_word(len, k), "R5", $sformatf("word %0d", k),
              out_data_o, exp_word(len, k));
        check(out_last_o == (k == len/8 - 1), "R6", $sformatf("last flag word %0d", k),
              {63'd0, out_last_o}, {63'd0, (k == len/8 - 1)});
      end
      hold = out_valid_o && !out_ready_i;
      prev = out_data_o;
      prev_last = out_last_o;
      @(negedge clk);
      start_i = 1'b0;
      if (fire) k++;
    end
    out_ready_i = 1'b0;
    check(!out_valid_o && !in_ready_o && !err_o, "R8", "quiet after last word",
          {61'd0, out_valid_o, in_ready_o, err_o}, 64'd0);
    in_valid_i = 1'b1;
    in_data_i  = 8'hee;
    repeat (3) begin
      @(negedge clk);
      check(!in_ready_o && !out_valid_o, "R8", "byte offered in idle not taken",
            {62'd0, in_ready_o, out_valid_o}, 64'd0);
    end
    in_valid_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] seed_str [16];
    void'($urandom(32'd20251));
    rst_n = 1'b0;
    start_i = 1'b0;
    len_i = '0;
    in_valid_i = 1'b0;
    in_data_i = '0;
    out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!in_ready_o && !out_valid_o && !err_o, "R1", "in reset",
          {61'd0, in_ready_o, out_valid_o, err_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!in_ready_o && !out_valid_o && !err_o, "R1", "after reset",
          {61'd0, in_ready_o, out_valid_o, err_o}, 64'd0);

    // directed: 13-byte integer, left-aligned and zero padded to 16
    seed_str = '{8'h12, 8'hab, 8'hcd, 8'hef, 8'h12, 8'h34, 8'h56, 8'h78,
                 8'h9a, 8'hbc, 8'hde, 8'hf0, 8'hf1, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 16; i++) buf_q[i] = seed_str[i];
    check(exp_word(16, 0) == 64'h000000f1f0debc9a, "R5", "model sanity",
          exp_word(16, 0), 64'h000000f1f0debc9a);
    run_op(16, 100, 100, 1'b0);

    // single word, full throughput and maximum size with gaps and stalls
    for (int i = 0; i < 256; i++) buf_q[i] = 8'($urandom);
    run_op(8, 100, 100, 1'b0);
    run_op(256, 100, 100, 1'b0);
    run_op(256, 40, 35, 1'b0);

    // R7: stray start pulses during load and emit
    run_op(64, 70, 60, 1'b1);
    run_op(24, 100, 100, 1'b1);

    // R3: refused lengths
    run_op(0, 100, 100, 1'b0);
    run_op(12, 100, 100, 1'b0);
    run_op(257, 100, 100, 1'b0);
    run_op(264, 100, 100, 1'b0);
    run_op(1023, 100, 100, 1'b0);
    run_op(4, 100, 100, 1'b0);

    // R9: random operands with random gaps and stalls
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < 256; i++) buf_q[i] = 8'($urandom);
      run_op(8 * $urandom_range(1, 32), $urandom_range(30, 100),
             $urandom_range(30, 100), ($urandom_range(3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule